// File: doc/BRIEF.md
# Floppy write serializer with load-time handshake

This block turns a stream of already-encoded group-code bytes into the serial write data line of a floppy drive. The host places each byte in a holding register. A parallel-load shift register takes that byte at a byte boundary and sends it out most significant bit first. A prescaler, selected by a two-bit speed-zone code, followed by a four-phase stage, sets the bit period. The shifter only loads on the last phase of that stage.

A one-cycle ready pulse fires at the moment a byte moves from the holding register into the shifter. It does not fire when the byte has finished shifting. The host therefore has a whole byte time to supply the next value. The pulse also sets a sticky flag, which the host clears explicitly. If no new byte arrives before the next boundary, the old holding value is shifted again. The write-enable input gates the line immediately. Dropping it discards any bits not yet sent, so a host that leaves write mode right after the last ready pulse truncates its final byte.

Top module: `disk_write_serializer`

## Requirements
- R1: A high `wr_i` at a clock edge stores `din_i` in the holding register. This happens whether the flag is set or clear, and the last write before a load is the byte that load takes.
- R2: Bits leave on `wdata_o` most significant first. Each bit is held for 4*(16-zone) clock cycles, so one byte spans 32*(16-zone) cycles. Zone is the unsigned value of `zone_i`: 0 gives the slowest rate and 3 the fastest.
- R3: After `wr_en_i` rises, the first load happens on the 4*(16-zone)-th rising edge with write enable high. `ready_o` is high in the cycle that follows that edge.
- R4: `ready_o` is a single-cycle pulse, one per load. Consecutive pulses are 32*(16-zone) cycles apart. The byte loaded is the holding value at the edge that raises the pulse.
- R5: `flag_o` becomes set in the cycle after a `ready_o` pulse. It stays set until `clr_i` is high at an edge while `ready_o` is low. If `clr_i` coincides with `ready_o`, the flag remains set.
- R6: When the host writes no new byte between two loads, the second load shifts the same holding value again.
- R7: While `wr_en_i` is low, `wdata_o` is 0 in the same cycle and the unsent shifter bits are discarded. The bit-rate phase restarts, so the next rise of `wr_en_i` follows R3 again. The holding register keeps its value.
- R8: Asynchronous reset clears the holding register and the flag, and drives `wdata_o` and `ready_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| zone_i | input | 2 | Speed zone; prescale ratio is 16 minus this value |
| wr_en_i | input | 1 | Write mode; gates the line and runs the bit timer |
| wr_i | input | 1 | Host write strobe for the holding register |
| din_i | input | 8 | Encoded byte from the host |
| clr_i | input | 1 | Clears the sticky ready flag |
| wdata_o | output | 1 | Serial write data |
| ready_o | output | 1 | One-cycle pulse at each shifter load |
| flag_o | output | 1 | Sticky copy of the ready pulse |

## Verification
A wrong prescaler or phase count shows up within the first byte after write enable rises, because the ready pulse then arrives at the wrong cycle. A misplaced bit count shows up within a single byte time, either as a corrupted mid-bit sample or as pulses at the wrong spacing. A shifter that is not flushed, or a phase that does not restart, shows up on the very next write-enable rise as a shifted first-ready latency or as stale leading bits. The bench samples every bit at its midpoint, over three consecutive bytes in each of the four zones.

// File: rtl/wsh_pkg.sv
package wsh_pkg;
  typedef logic [1:0] zone_t;

  // prescale terminal count for a zone
  function automatic int unsigned zone_last(input int unsigned base, input zone_t z);
    return base - 1 - int'(z);
  endfunction
endpackage

// File: rtl/wsh_divider.sv
module wsh_divider #(
  parameter int unsigned BASE_DIV = 16,
  parameter int unsigned PHASES   = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  wsh_pkg::zone_t zone_i,
  output logic           bit_tick_o
);
  localparam int unsigned PRE_W = $clog2(BASE_DIV);
  localparam int unsigned PH_W  = (PHASES > 1) ? $clog2(PHASES) : 1;

  logic [PRE_W-1:0] pre_q;
  logic [PH_W-1:0]  ph_q;
  logic [PRE_W-1:0] pre_last;
  logic             pre_tick;
  logic             ph_last;

  assign pre_last   = PRE_W'(wsh_pkg::zone_last(BASE_DIV, zone_i));
  assign pre_tick   = (pre_q >= pre_last);
  assign ph_last    = (ph_q == PH_W'(PHASES - 1));
  // load phase qualification: only the last phase produces a bit boundary
  assign bit_tick_o = run_i & pre_tick & ph_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      ph_q  <= '0;
    end else if (!run_i) begin
      pre_q <= '0;
      ph_q  <= '0;
    end else if (pre_tick) begin
      pre_q <= '0;
      ph_q  <= ph_last ? '0 : ph_q + PH_W'(1);
    end else begin
      pre_q <= pre_q + PRE_W'(1);
    end
  end

  a_r2_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |=> !bit_tick_o);

  a_r7_phase_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (pre_q == '0 && ph_q == '0 && !bit_tick_o));
endmodule

// File: rtl/wsh_shifter.sv
module wsh_shifter #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              bit_tick_i,
  input  logic [BYTE_W-1:0] hold_i,
  output logic              load_o,
  output logic              sdata_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);

  logic [BYTE_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  assign load_o  = bit_tick_i & (cnt_q == '0);
  assign sdata_o = run_i & sh_q[BYTE_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (!run_i) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load_o) begin
      sh_q  <= hold_i;
      cnt_q <= CNT_W'(BYTE_W - 1);
    end else if (bit_tick_i) begin
      sh_q  <= sh_q << 1;
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  a_r6_load_takes_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> (sh_q == $past(hold_i)));

  a_r7_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (sh_q == '0 && cnt_q == '0));
endmodule

// File: rtl/wsh_handshake.sv
module wsh_handshake #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] din_i,
  input  logic              load_i,
  input  logic              clr_i,
  output logic [BYTE_W-1:0] hold_o,
  output logic              ready_o,
  output logic              flag_o
);
  logic [BYTE_W-1:0] hold_q;
  logic              rdy_q;
  logic              flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      rdy_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_i) hold_q <= din_i;
      rdy_q <= load_i;
      // set dominates clear so a coincident pulse is not lost
      if (rdy_q)      flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign hold_o  = hold_q;
  assign ready_o = rdy_q;
  assign flag_o  = flag_q;

  a_r1_hold_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (hold_q == $past(din_i)));

  a_r4_ready_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_q |=> !rdy_q);

  a_r5_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_q |=> flag_q);

  a_r5_flag_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !rdy_q) |=> !flag_q);
endmodule

// File: rtl/disk_write_serializer.sv
module disk_write_serializer #(
  parameter int unsigned BASE_DIV = 16,
  parameter int unsigned PHASES   = 4,
  parameter int unsigned BYTE_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        zone_i,
  input  logic              wr_en_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] din_i,
  input  logic              clr_i,
  output logic              wdata_o,
  output logic              ready_o,
  output logic              flag_o
);
  logic              bit_tick;
  logic              load;
  logic [BYTE_W-1:0] hold;

  wsh_divider #(.BASE_DIV(BASE_DIV), .PHASES(PHASES)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (wr_en_i),
    .zone_i     (zone_i),
    .bit_tick_o (bit_tick)
  );

  wsh_shifter #(.BYTE_W(BYTE_W)) u_sh (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (wr_en_i),
    .bit_tick_i (bit_tick),
    .hold_i     (hold),
    .load_o     (load),
    .sdata_o    (wdata_o)
  );

  wsh_handshake #(.BYTE_W(BYTE_W)) u_hs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .din_i   (din_i),
    .load_i  (load),
    .clr_i   (clr_i),
    .hold_o  (hold),
    .ready_o (ready_o),
    .flag_o  (flag_o)
  );

  a_r4_ready_follows_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> ready_o);

  a_r7_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> !ready_o);
endmodule

// File: tb/tb_disk_write_serializer.sv
`timescale 1ns/1ps
module tb_disk_write_serializer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] zone_i = '0;
  logic       wr_en_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] din_i = '0;
  logic       clr_i = 1'b0;
  logic       wdata_o, ready_o, flag_o;

  always #2.5 clk_i = ~clk_i;

  disk_write_serializer dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .zone_i(zone_i), .wr_en_i(wr_en_i),
    .wr_i(wr_i), .din_i(din_i), .clr_i(clr_i),
    .wdata_o(wdata_o), .ready_o(ready_o), .flag_o(flag_o)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // {zone, first byte, second byte}
  localparam logic [17:0] VEC [4] = '{
    {2'd0, 8'hA5, 8'h3C},
    {2'd1, 8'h0F, 8'hF0},
    {2'd2, 8'h55, 8'hC3},
    {2'd3, 8'h81, 8'h7E}
  };

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    int r;
    int k;
    logic [7:0] b0, b1;

    // R8 reset state
    repeat (3) @(negedge clk_i);
    chk(wdata_o == 1'b0, "R8 wdata", int'(wdata_o), 0);
    chk(ready_o == 1'b0, "R8 ready", int'(ready_o), 0);
    chk(flag_o  == 1'b0, "R8 flag",  int'(flag_o), 0);
    rst_ni = 1'b1;

    // R7 idle: byte present but write mode low, line stays quiet
    @(negedge clk_i); wr_i = 1'b1; din_i = 8'hFF;
    @(negedge clk_i); wr_i = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk_i);
      if (wdata_o || ready_o)
        chk(1'b0, "R7 idle", int'({wdata_o, ready_o}), 0);
    end
    chk(1'b1, "R7 idle", 0, 0);

    for (int v = 0; v < 4; v++) begin
      zone_i = VEC[v][17:16];
      b0     = VEC[v][15:8];
      b1     = VEC[v][7:0];
      r      = 16 - int'(VEC[v][17:16]);

      // R1: overwrite before load, last write wins
      @(negedge clk_i); wr_i = 1'b1; din_i = ~b0;
      @(negedge clk_i); din_i = b0;
      @(negedge clk_i); wr_i = 1'b0; clr_i = 1'b1;
      @(negedge clk_i); clr_i = 1'b0;
      @(negedge clk_i);
      chk(flag_o == 1'b0, "R5 clear before run", int'(flag_o), 0);

      // R3 first-load latency
      wr_en_i = 1'b1;
      k = 0;
      do begin
        @(negedge clk_i);
        k++;
      end while (!ready_o && k < 1000);
      chk(k == 4 * r, "R3 first ready", k, 4 * r);

      for (int t = 1; t <= 96 * r; t++) begin
        int j;
        int w;
        int bi;
        logic [7:0] e;
        @(negedge clk_i);
        j = t / (32 * r);
        w = t % (32 * r);
        e = (j == 0) ? b0 : b1;
        if (w == 0) chk(ready_o == 1'b1, "R4 ready period", int'(ready_o), 1);
        if (w == 1) chk(ready_o == 1'b0, "R4 single pulse", int'(ready_o), 0);
        if (w % (4 * r) == 2 * r) begin
          bi = 7 - w / (4 * r);
          if (j == 2) chk(wdata_o == e[bi], "R6 stale reload bit", int'(wdata_o), int'(e[bi]));
          else        chk(wdata_o == e[bi], "R2 serial bit", int'(wdata_o), int'(e[bi]));
        end
        // host actions
        if (t == 1) clr_i = 1'b1;
        if (t == 2) clr_i = 1'b0;
        if (t == 3) chk(flag_o == 1'b0, "R5 cleared", int'(flag_o), 0);
        if (t == 4) begin wr_i = 1'b1; din_i = b1; end   // R1 write with flag clear
        if (t == 5) wr_i = 1'b0;
        if (t == 32 * r) clr_i = 1'b1;                    // coincides with ready
        if (t == 32 * r + 1) clr_i = 1'b0;
        if (t == 32 * r + 2) chk(flag_o == 1'b1, "R5 set wins", int'(flag_o), 1);
      end

      // R7 truncation mid-byte
      repeat (2 * r) @(negedge clk_i);
      chk(wdata_o == b1[7], "R2 before drop", int'(wdata_o), int'(b1[7]));
      wr_en_i = 1'b0;
      #1;
      chk(wdata_o == 1'b0, "R7 cut at once", int'(wdata_o), 0);
      repeat (40 * r) begin
        @(negedge clk_i);
        if (wdata_o || ready_o)
          chk(1'b0, "R7 stays off", int'({wdata_o, ready_o}), 0);
      end
      chk(flag_o == 1'b1, "R5 sticky", int'(flag_o), 1);
    end

    // R7 holding kept across idle: restart without writing reloads the old byte
    zone_i = 2'd3;
    @(negedge clk_i); wr_en_i = 1'b1;
    k = 0;
    do begin
      @(negedge clk_i);
      k++;
    end while (!ready_o && k < 1000);
    chk(k == 52, "R3 restart latency", k, 52);
    for (int i = 0; i < 8; i++) begin
      repeat (26) @(negedge clk_i);
      chk(wdata_o == VEC[3][7 - i], "R7 hold retained", int'(wdata_o), int'(VEC[3][7 - i]));
      repeat (26) @(negedge clk_i);
    end

    finish_run();
  end
endmodule